// File: doc/BRIEF.md
# Master-Filtered Bus Slave Decoder

This block sits on the slave side of a processor bus and decides whether each address tenure belongs to it. It compares every tenure against four programmable windows. Each window has a base, a size mask, an enable, a master-filter enable, three master-select bits and a single-beat-only flag. The block claims a tenure only when one window hits, the transfer-type code belongs to a supported class and, where master filtering applies, the current bus owner is one of the masters that window selects.

A claimed tenure produces a one-clock claim strobe and an address-acknowledge pulse in the clock after the address-start strobe. That same clock also carries the index of the winning window and the class of the tenure: address-only, read (delayed handling) or write (posted handling). Address-only cache and ordering operations are acknowledged with no data phase. The bus arbiter lies outside this block. It appears only as an arbiter-enable input and the ID of the granted master.

A three-state machine drives the outputs. `ST_IDLE` is the rest state. `ST_ACK` is the clock after a claimed start. `ST_SKIP` is the clock after an unclaimed start. On every clock the next state is `ST_ACK` when a start arrives and qualifies (transition "claim"), `ST_SKIP` when a start arrives and does not qualify (transition "reject"), and `ST_IDLE` otherwise (transition "settle"). These transitions apply from every state, so starts may come back to back.

Top module: `mfsd_slave_decoder`

## Requirements
- R1: A window hits when it is enabled and `((addr ^ base) & mask) == 0`. Mask bits set to 1 are compared. A disabled window never hits.
- R2: Only the eight transfer-type codes below are supported. No other code is ever claimed, whatever the address.
- R3: Codes 00000, 00100, 01000 and 01100 are address-only, class 1. They are claimed and acknowledged with no data phase, and the single-beat-only flag does not affect them.
- R4: Codes 01010 and 01110 are reads, class 2 (delayed). Codes 00010 and 00110 are writes, class 3 (posted).
- R5: Master filtering for a window applies only when `arb_en` is 1 and that window's `cfg_mdec` bit is 1. Otherwise the owner ID has no effect on that window.
- R6: When filtering applies, an owner ID n in 1..3 passes only if bit n-1 of the window's master-select field is 1. Owner ID 0 never passes.
- R7: A window with its single-beat-only flag set claims a read or write only when `single_beat` is 1.
- R8: `aack` and `claim` are high together for exactly the one clock after an `addr_start` clock that qualifies, and never after one that does not. `claim_win` and `claim_cls` are valid in that clock and zero otherwise.
- R9: When several windows qualify, the lowest-numbered one wins. `conflict` goes to 1 and stays 1 until reset.
- R10: During and just after reset, `claim`, `aack` and `conflict` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_en | input | 1 | Internal arbiter enabled |
| owner_id | input | 2 | ID of the master owning the bus (0 = none/internal) |
| addr_start | input | 1 | Address-start strobe, one clock per tenure |
| addr | input | AW (32) | Tenure address |
| ttype | input | 5 | Transfer-type code |
| single_beat | input | 1 | 1 = single-beat transfer, 0 = burst |
| cfg_en | input | NWIN (4) | Window enables |
| cfg_base | input | NWIN*AW | Window bases, window i in bits [i*AW +: AW] |
| cfg_mask | input | NWIN*AW | Window compare masks |
| cfg_mdec | input | NWIN | Master-filter enables |
| cfg_msel | input | NWIN*3 | Master selects, window i in bits [i*3 +: 3] |
| cfg_single_only | input | NWIN | Reject bursts (register/I/O windows) |
| claim | output | 1 | Claim strobe |
| aack | output | 1 | Address-acknowledge pulse |
| claim_win | output | 2 | Winning window index |
| claim_cls | output | 2 | Class: 1 address-only, 2 read, 3 write |
| conflict | output | 1 | Sticky multiple-window-qualify flag |

## Verification
The hardest case to reach is the overlap conflict. Two windows with the same range and distinct master selects are legal on their own, so a conflict appears only when filtering is switched off for both of them at once. The bench first walks a table that keeps the windows overlapping but filtered, and checks that `conflict` is still clear. It then drops `arb_en` so that both windows qualify, and checks three things: the lower index wins, the flag stays set through a later clean tenure, and only reset clears it.

// File: rtl/mfsd_pkg.sv
package mfsd_pkg;

    typedef enum logic [1:0] {
        CLS_NONE      = 2'd0,
        CLS_ADDR_ONLY = 2'd1,
        CLS_READ      = 2'd2,
        CLS_WRITE     = 2'd3
    } xfer_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_SKIP = 2'd2
    } dec_state_e;

    localparam int TTW = 5;

    // Address-only cache / ordering operations
    localparam logic [TTW-1:0] TT_CLEAN    = 5'b00000;
    localparam logic [TTW-1:0] TT_FLUSH    = 5'b00100;
    localparam logic [TTW-1:0] TT_SYNC     = 5'b01000;
    localparam logic [TTW-1:0] TT_KILL     = 5'b01100;
    // Data transfers
    localparam logic [TTW-1:0] TT_WR_FLUSH = 5'b00010;
    localparam logic [TTW-1:0] TT_WR_KILL  = 5'b00110;
    localparam logic [TTW-1:0] TT_RD       = 5'b01010;
    localparam logic [TTW-1:0] TT_RD_MOD   = 5'b01110;

    localparam int MSELW = 3;

endpackage

// File: rtl/mfsd_tt_classify.sv
module mfsd_tt_classify
    import mfsd_pkg::*;
(
    input  logic [TTW-1:0] ttype,
    output xfer_cls_e      cls
);

    always_comb begin
        unique case (ttype)
            TT_CLEAN, TT_FLUSH, TT_SYNC, TT_KILL: cls = CLS_ADDR_ONLY;
            TT_RD, TT_RD_MOD:                     cls = CLS_READ;
            TT_WR_FLUSH, TT_WR_KILL:              cls = CLS_WRITE;
            default:                              cls = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/mfsd_window_match.sv
module mfsd_window_match
    import mfsd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    addr,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    mask,
    input  logic             en,
    input  logic             mdec,
    input  logic [MSELW-1:0] msel,
    input  logic             single_only,
    input  logic             arb_en,
    input  logic [1:0]       owner_id,
    input  logic             single_beat,
    input  xfer_cls_e        cls,
    output logic             qualify
);

    logic addr_hit;
    logic filt_on;
    logic master_ok;
    logic is_data;
    logic beat_ok;

    assign addr_hit = en && (((addr ^ base) & mask) == '0);
    assign filt_on  = arb_en && mdec;

    // Owner IDs 1..3 select msel bits 0..2; ID 0 never matches.
    always_comb begin
        unique case (owner_id)
            2'd1:    master_ok = msel[0];
            2'd2:    master_ok = msel[1];
            2'd3:    master_ok = msel[2];
            default: master_ok = 1'b0;
        endcase
    end

    assign is_data = (cls == CLS_READ) || (cls == CLS_WRITE);
    assign beat_ok = !single_only || !is_data || single_beat;

    assign qualify = addr_hit && (cls != CLS_NONE) && beat_ok
                  && (!filt_on || master_ok);

endmodule

// File: rtl/mfsd_prio_pick.sv
module mfsd_prio_pick #(
    parameter int NWIN = 4,
    localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int CW = $clog2(NWIN + 1)
) (
    input  logic [NWIN-1:0] qual,
    output logic            any,
    output logic            multi,
    output logic [IW-1:0]   idx
);

    logic [CW-1:0] cnt;

    always_comb begin
        any = 1'b0;
        idx = '0;
        cnt = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (qual[i]) begin
                any = 1'b1;
                idx = IW'(i);
                cnt = cnt + CW'(1);
            end
        end
        multi = (cnt > CW'(1));
    end

endmodule

// File: rtl/mfsd_slave_decoder.sv
module mfsd_slave_decoder
    import mfsd_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NWIN = 4,
    localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arb_en,
    input  logic [1:0]            owner_id,
    input  logic                  addr_start,
    input  logic [AW-1:0]         addr,
    input  logic [TTW-1:0]        ttype,
    input  logic                  single_beat,
    input  logic [NWIN-1:0]       cfg_en,
    input  logic [NWIN*AW-1:0]    cfg_base,
    input  logic [NWIN*AW-1:0]    cfg_mask,
    input  logic [NWIN-1:0]       cfg_mdec,
    input  logic [NWIN*MSELW-1:0] cfg_msel,
    input  logic [NWIN-1:0]       cfg_single_only,
    output logic                  claim,
    output logic                  aack,
    output logic [IW-1:0]         claim_win,
    output logic [1:0]            claim_cls,
    output logic                  conflict
);

    xfer_cls_e       cls;
    logic [NWIN-1:0] qual;
    logic            any_q;
    logic            multi_q;
    logic [IW-1:0]   pick;

    dec_state_e      state, state_nxt;
    logic [IW-1:0]   win_r;
    xfer_cls_e       cls_r;
    logic            conflict_r;

    mfsd_tt_classify u_cls (
        .ttype (ttype),
        .cls   (cls)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        mfsd_window_match #(.AW(AW)) u_match (
            .addr        (addr),
            .base        (cfg_base[w*AW +: AW]),
            .mask        (cfg_mask[w*AW +: AW]),
            .en          (cfg_en[w]),
            .mdec        (cfg_mdec[w]),
            .msel        (cfg_msel[w*MSELW +: MSELW]),
            .single_only (cfg_single_only[w]),
            .arb_en      (arb_en),
            .owner_id    (owner_id),
            .single_beat (single_beat),
            .cls         (cls),
            .qualify     (qual[w])
        );
    end

    mfsd_prio_pick #(.NWIN(NWIN)) u_pick (
        .qual  (qual),
        .any   (any_q),
        .multi (multi_q),
        .idx   (pick)
    );

    // Next-state: claim / reject / settle, same from every state.
    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_ACK, ST_SKIP: begin
                if (addr_start)
                    state_nxt = any_q ? ST_ACK : ST_SKIP;
                else
                    state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Tenure capture and sticky conflict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_r      <= '0;
            cls_r      <= CLS_NONE;
            conflict_r <= 1'b0;
        end else if (addr_start) begin
            if (any_q) begin
                win_r <= pick;
                cls_r <= cls;
            end
            if (multi_q) conflict_r <= 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        claim     = 1'b0;
        aack      = 1'b0;
        claim_win = '0;
        claim_cls = CLS_NONE;
        unique case (state)
            ST_ACK: begin
                claim     = 1'b1;
                aack      = 1'b1;
                claim_win = win_r;
                claim_cls = cls_r;
            end
            ST_IDLE, ST_SKIP: ;
            default: ;
        endcase
    end

    assign conflict = conflict_r;

endmodule

// File: rtl/mfsd_slave_decoder_chk.sv
module mfsd_slave_decoder_chk
    import mfsd_pkg::*;
#(
    parameter int NWIN = 4,
    localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            arb_en,
    input logic [1:0]      owner_id,
    input logic            addr_start,
    input logic [TTW-1:0]  ttype,
    input logic            single_beat,
    input logic [NWIN-1:0] cfg_mdec,
    input logic [NWIN-1:0] cfg_single_only,
    input logic            claim,
    input logic            aack,
    input logic [1:0]      claim_cls,
    input logic            conflict
);

    AST_ACK_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        aack |-> $past(addr_start)); // R8

    AST_ACK_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (aack && !addr_start) |=> !aack); // R8

    AST_CLAIM_HAS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> (claim_cls != 2'd0)); // R2

    AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_start && ttype == 5'b11111) |=> !claim); // R2

    AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> conflict); // R9

    AST_ID0_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_start && arb_en && owner_id == 2'd0 && (&cfg_mdec)) |=> !claim); // R6

    AST_BURST_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_start && !single_beat && (&cfg_single_only) && ttype == TT_RD) |=> !claim); // R7

endmodule

bind mfsd_slave_decoder mfsd_slave_decoder_chk #(.NWIN(NWIN)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .arb_en          (arb_en),
    .owner_id        (owner_id),
    .addr_start      (addr_start),
    .ttype           (ttype),
    .single_beat     (single_beat),
    .cfg_mdec        (cfg_mdec),
    .cfg_single_only (cfg_single_only),
    .claim           (claim),
    .aack            (aack),
    .claim_cls       (claim_cls),
    .conflict        (conflict)
);

// File: tb/test_mfsd_slave_decoder.sv
`timescale 1ns/1ps
module test_mfsd_slave_decoder;

    localparam int AW = 32;
    localparam int NWIN = 4;
    localparam int NV = 17;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            arb_en = 1'b1;
    logic [1:0]      owner_id = '0;
    logic            addr_start = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [4:0]      ttype = '0;
    logic            single_beat = 1'b0;
    logic [NWIN-1:0] cfg_en;
    logic [NWIN*AW-1:0] cfg_base;
    logic [NWIN*AW-1:0] cfg_mask;
    logic [NWIN-1:0] cfg_mdec;
    logic [NWIN*3-1:0] cfg_msel;
    logic [NWIN-1:0] cfg_single_only;
    logic            claim, aack, conflict;
    logic [1:0]      claim_win, claim_cls;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mfsd_slave_decoder #(.AW(AW), .NWIN(NWIN)) i_mfsd_slave_decoder (
        .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .owner_id(owner_id),
        .addr_start(addr_start), .addr(addr), .ttype(ttype),
        .single_beat(single_beat), .cfg_en(cfg_en), .cfg_base(cfg_base),
        .cfg_mask(cfg_mask), .cfg_mdec(cfg_mdec), .cfg_msel(cfg_msel),
        .cfg_single_only(cfg_single_only), .claim(claim), .aack(aack),
        .claim_win(claim_win), .claim_cls(claim_cls), .conflict(conflict)
    );

    // {addr, ttype, single, owner, arb_en, exp_claim, exp_win, exp_cls}
    localparam logic [45:0] VEC [NV] = '{
        {32'h1000_0040, 5'b01010, 1'b0, 2'd1, 1'b1, 1'b1, 2'd0, 2'd2}, // R4 read
        {32'h1000_FFFC, 5'b00010, 1'b0, 2'd1, 1'b1, 1'b1, 2'd0, 2'd3}, // R4 write
        {32'h1001_0000, 5'b01010, 1'b0, 2'd1, 1'b1, 1'b0, 2'd0, 2'd0}, // R1 miss
        {32'h1000_0000, 5'b00000, 1'b0, 2'd1, 1'b1, 1'b1, 2'd0, 2'd1}, // R3 clean
        {32'h1000_0000, 5'b01100, 1'b0, 2'd1, 1'b1, 1'b1, 2'd0, 2'd1}, // R3 kill
        {32'h1000_0000, 5'b11111, 1'b0, 2'd1, 1'b1, 1'b0, 2'd0, 2'd0}, // R2
        {32'h1000_0000, 5'b01011, 1'b0, 2'd1, 1'b1, 1'b0, 2'd0, 2'd0}, // R2
        {32'h2000_0010, 5'b01010, 1'b0, 2'd2, 1'b1, 1'b1, 2'd1, 2'd2}, // R6 owner 2
        {32'h2000_0010, 5'b01010, 1'b0, 2'd1, 1'b1, 1'b1, 2'd3, 2'd2}, // R6 owner 1
        {32'h2000_0010, 5'b00110, 1'b0, 2'd3, 1'b1, 1'b1, 2'd3, 2'd3}, // R6 owner 3
        {32'h2000_0010, 5'b01010, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 2'd0}, // R6 owner 0
        {32'h3000_0004, 5'b00010, 1'b0, 2'd1, 1'b1, 1'b0, 2'd0, 2'd0}, // R7 burst
        {32'h3000_0004, 5'b00010, 1'b1, 2'd1, 1'b1, 1'b1, 2'd2, 2'd3}, // R7 single
        {32'h3000_0004, 5'b01000, 1'b0, 2'd1, 1'b1, 1'b1, 2'd2, 2'd1}, // R3 sync
        {32'h3000_0100, 5'b01010, 1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 2'd0}, // R1 miss
        {32'h1000_0008, 5'b01110, 1'b0, 2'd1, 1'b1, 1'b1, 2'd0, 2'd2}, // R4 read-mod
        {32'h2000_1000, 5'b01010, 1'b0, 2'd2, 1'b1, 1'b0, 2'd0, 2'd0}  // R1 miss
    };

    function automatic string vec_req(int i);
        case (i)
            0, 1, 15:  return "R4";
            2, 14, 16: return "R1";
            3, 4, 13:  return "R3";
            5, 6:      return "R2";
            11, 12:    return "R7";
            default:   return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [4:0] t, logic s, logic [1:0] o, logic ae);
        @(negedge clk);
        addr = a; ttype = t; single_beat = s; owner_id = o; arb_en = ae;
        addr_start = 1'b1;
        @(negedge clk);
        addr_start = 1'b0;
    endtask

    task automatic expect_claim(string req, logic ec, logic [1:0] ew, logic [1:0] ecl);
        check(req, {claim, aack, claim_win, claim_cls},
              {ec, ec, (ec ? ew : 2'd0), (ec ? ecl : 2'd0)});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", {31'd0, claim}, 32'd0);
        check("R10", {31'd0, aack}, 32'd0);
        check("R10", {31'd0, conflict}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {30'd0, aack, conflict}, 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cfg_en          = 4'b1111;
        cfg_base        = {32'h2000_0000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000};
        cfg_mask        = {32'hFFFF_F000, 32'hFFFF_FF00, 32'hFFFF_F000, 32'hFFFF_0000};
        cfg_mdec        = 4'b1010;
        cfg_msel        = {3'b101, 3'b000, 3'b010, 3'b000};
        cfg_single_only = 4'b0100;

        do_reset();

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][45:14], VEC[i][13:9], VEC[i][8], VEC[i][7:6], VEC[i][5]);
            expect_claim(vec_req(i), VEC[i][4], VEC[i][3:2], VEC[i][1:0]);
            @(negedge clk);
            check("R8", {31'd0, aack}, 32'd0);
        end

        // R9: legal overlap with distinct masters leaves conflict clear
        check("R9", {31'd0, conflict}, 32'd0);

        // R1: disabled window never hits
        cfg_en[0] = 1'b0;
        apply(32'h1000_0040, 5'b01010, 1'b0, 2'd1, 1'b1);
        expect_claim("R1", 1'b0, 2'd0, 2'd0);
        cfg_en[0] = 1'b1;

        // R8: back-to-back starts, claimed then unsupported
        @(negedge clk);
        addr = 32'h1000_0040; ttype = 5'b01010; owner_id = 2'd1; arb_en = 1'b1;
        addr_start = 1'b1;
        @(negedge clk);
        expect_claim("R8", 1'b1, 2'd0, 2'd2);
        ttype = 5'b10101;
        @(negedge clk);
        addr_start = 1'b0;
        expect_claim("R8", 1'b0, 2'd0, 2'd0);

        // R5: arbiter disabled, owner 0 still claims filtered window 3
        cfg_en[1] = 1'b0;
        apply(32'h2000_0020, 5'b01010, 1'b0, 2'd0, 1'b0);
        expect_claim("R5", 1'b1, 2'd3, 2'd2);
        check("R9", {31'd0, conflict}, 32'd0);
        cfg_en[1] = 1'b1;

        // R9: windows 1 and 3 both qualify; lowest wins, conflict sticks
        apply(32'h2000_0020, 5'b00010, 1'b0, 2'd0, 1'b0);
        expect_claim("R9", 1'b1, 2'd1, 2'd3);
        check("R9", {31'd0, conflict}, 32'd1);
        apply(32'h1000_0000, 5'b01010, 1'b0, 2'd1, 1'b1);
        expect_claim("R9", 1'b1, 2'd0, 2'd2);
        check("R9", {31'd0, conflict}, 32'd1);

        // R10: reset clears the sticky flag
        do_reset();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule